// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This unit sits behind a bank of timer channels and turns each channel's fire event into an interrupt. A fire counts only when the channel is enabled and the global enable is on. It is then delivered in one of two ways:

- **Interrupt line.** The line is either a held level or a single-cycle pulse. It is taken from the channel's route field. In legacy mode, channels 0 and 1 use fixed lines instead.
- **Message write.** A write of an address and a data word, held on a valid/ready handshake until accepted.

An external real-time-clock interrupt level is forwarded to line 8. This happens only while legacy mode is off, because legacy mode gives line 8 to channel 1.

All line outputs are registered. A fire sampled on one clock edge is visible on the lines just after that edge. Lines targeted by several sources carry the OR of those sources. Per-channel status bits record pending level interrupts until they are cleared.

Top module: `tmr_irq_router`

## Requirements
- R1: With legacy mode off, a delivered fire on channel i drives line `ch_route[i*RW +: RW]` (the route field is the binary line index). The line rises right after the clock edge that samples the fire.
- R2: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Channels 2 and up still follow their route fields.
- R3: A fire is delivered only when both `ch_en[i]` and `glb_en` are 1. Otherwise it changes no line, status bit or message.
- R4: In level mode (`ch_level[i]`=1), a delivered fire sets `status[i]`, and the line stays high until the status is cleared.
- R5: In edge mode (`ch_level[i]`=0), a delivered fire gives a line pulse of exactly one cycle and leaves `status[i]` at 0.
- R6: With `ch_msg_en[i]`=1, a delivered fire drives no line and sets no status. Instead it presents `msg_valid` with `msg_addr` = `ch_msg_cfg[i*64+32 +: 32]` and `msg_data` = `ch_msg_cfg[i*64 +: 32]`.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, the message address and data stay stable. When several channels have messages pending, the lowest channel index is presented first.
- R8: Any of the following clears `status[i]` and lowers its line on the next edge:
  - `clr[i]`;
  - `ch_en[i]`=0;
  - `glb_en`=0;
  - a 0-to-1 change of `ch_msg_en[i]`.
  A delivered level fire in the same cycle wins over the clear.
- R9: Line outputs are the OR of all sources targeting them. Clearing one of two channels that share a line keeps the line high.
- R10: With legacy mode off, line 8 follows `rtc_irq_in` one cycle later. Entering legacy mode removes the RTC level from line 8, and leaving legacy mode restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy fixed routing for channels 0 and 1 |
| ch_en | input | N_CH | Per-channel enable |
| ch_level | input | N_CH | 1 = level mode, 0 = pulse mode |
| ch_msg_en | input | N_CH | Deliver by message write instead of line |
| ch_route | input | N_CH*RW | Per-channel target line index |
| ch_msg_cfg | input | N_CH*64 | Per channel: address in high 32 bits, data in low 32 bits |
| fire | input | N_CH | Channel fire events |
| clr | input | N_CH | Per-channel status clear |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| irq_lines | output | N_LINES | Registered interrupt lines |
| status | output | N_CH | Pending level-interrupt status |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Some properties are checked on every cycle:
- the message handshake holding its payload stable;
- the RTC level reaching line 8 while legacy mode is off;
- global disable and clear emptying the status bits.

Other behaviours are visible only through the bench's scenarios:
- the route sweep over every channel, line, mode and legacy setting;
- lowest-index message ordering;
- clear-versus-fire precedence;
- OR merging of shared lines.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int N_CH    = 4,
  parameter int N_LINES = 16,
  localparam int RW     = $clog2(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic                 legacy_en,
  input  logic [N_CH-1:0]      ch_en,
  input  logic [N_CH-1:0]      ch_level,
  input  logic [N_CH-1:0]      ch_msg_en,
  input  logic [N_CH*RW-1:0]   ch_route,
  input  logic [N_CH*64-1:0]   ch_msg_cfg,
  input  logic [N_CH-1:0]      fire,
  input  logic [N_CH-1:0]      clr,
  input  logic                 rtc_irq_in,
  output logic [N_LINES-1:0]   irq_lines,
  output logic [N_CH-1:0]      status,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int RTC_LINE = 8;

  logic [N_CH-1:0]    deliver, msg_rise, msg_en_q, status_d, src;
  logic [N_CH-1:0]    pend_q, pend_nxt, pick;
  logic [N_LINES-1:0] lines_d;
  logic [31:0]        sel_addr, sel_data;

  assign deliver  = fire & ch_en & {N_CH{glb_en}};
  assign msg_rise = ch_msg_en & ~msg_en_q;
  assign pend_nxt = pend_q | (deliver & ch_msg_en);
  assign pick     = pend_nxt & (~pend_nxt + 1'b1);

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      status_d[i] = status[i];
      if (clr[i] || !ch_en[i] || !glb_en || msg_rise[i]) status_d[i] = 1'b0;
      if (deliver[i] && ch_level[i] && !ch_msg_en[i])     status_d[i] = 1'b1;
    end
    src = status_d | (deliver & ~ch_level & ~ch_msg_en);
  end

  always_comb begin
    logic [RW-1:0] tgt;
    lines_d = '0;
    lines_d[RTC_LINE] = rtc_irq_in & ~legacy_en;
    for (int i = 0; i < N_CH; i++) begin
      tgt = ch_route[i*RW +: RW];
      if (legacy_en && i == 0) tgt = '0;
      if (legacy_en && i == 1) tgt = RW'(RTC_LINE);
      if (src[i]) lines_d[tgt] = 1'b1;
    end
  end

  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    for (int i = 0; i < N_CH; i++)
      if (pick[i]) begin
        sel_addr = ch_msg_cfg[i*64+32 +: 32];
        sel_data = ch_msg_cfg[i*64 +: 32];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lines <= '0;
      status    <= '0;
      msg_en_q  <= '0;
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_lines <= lines_d;
      status    <= status_d;
      msg_en_q  <= ch_msg_en;
      if (!msg_valid || msg_ready) begin
        msg_valid <= |pend_nxt;
        pend_q    <= pend_nxt & ~pick;
        if (|pend_nxt) begin
          msg_addr <= sel_addr;
          msg_data <= sel_data;
        end
      end else begin
        pend_q <= pend_nxt;
      end
    end
  end

  a_r7_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r10_rtc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_en && rtc_irq_in) |=> irq_lines[RTC_LINE]);

  a_r8_glb_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (status == '0));

  a_r8_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((status & $past(clr & ~(fire & ch_en & {N_CH{glb_en}} & ch_level & ~ch_msg_en))) == '0));

  a_r3_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !msg_valid && pend_q == '0) |=> !msg_valid);
endmodule

// File: tb/tmr_irq_router_tb_top.sv
module tmr_irq_router_tb_top;
  localparam int N_CH = 4, N_LINES = 16, RW = 4;

  logic clk = 0, rst_n = 0;
  logic glb_en, legacy_en, rtc_irq_in, msg_ready;
  logic [N_CH-1:0] ch_en, ch_level, ch_msg_en, fire, clr;
  logic [N_CH*RW-1:0] ch_route;
  logic [N_CH*64-1:0] ch_msg_cfg;
  logic [N_LINES-1:0] irq_lines;
  logic [N_CH-1:0] status;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_router #(.N_CH(N_CH), .N_LINES(N_LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
    .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
    .ch_route(ch_route), .ch_msg_cfg(ch_msg_cfg), .fire(fire), .clr(clr),
    .rtc_irq_in(rtc_irq_in), .irq_lines(irq_lines), .status(status),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  function automatic logic [31:0] addr_of(int i); return 32'hA000_0000 + 32'(i * 16); endfunction
  function automatic logic [31:0] data_of(int i); return 32'h5500_0000 + 32'(i); endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    glb_en = 1; legacy_en = 0; rtc_irq_in = 0; msg_ready = 0;
    ch_en = '1; ch_level = '0; ch_msg_en = '0; fire = '0; clr = '0; ch_route = '0;
    for (int i = 0; i < N_CH; i++) ch_msg_cfg[i*64 +: 64] = {addr_of(i), data_of(i)};
    nxt(); nxt();
    chk("reset lines", 64'(irq_lines), 0);
    chk("reset status", 64'(status), 0);
    chk("reset msg_valid", 64'(msg_valid), 0);
    rst_n = 1;
    nxt();

    // R1 R2 R4 R5 R8 sweep over legacy, channel, route, mode
    for (int leg = 0; leg < 2; leg++)
      for (int ch = 0; ch < N_CH; ch++)
        for (int r = 0; r < N_LINES; r++)
          for (int lvl = 0; lvl < 2; lvl++) begin
            int tgt;
            string rt;
            tgt = (leg == 1 && ch == 0) ? 0 : (leg == 1 && ch == 1) ? 8 : r;
            rt = leg ? "R2 route" : "R1 route";
            legacy_en = leg[0];
            for (int k = 0; k < N_CH; k++) ch_route[k*RW +: RW] = RW'(r);
            ch_level = lvl ? '1 : '0;
            fire = 4'(1 << ch);
            nxt();
            fire = '0;
            chk(rt, 64'(irq_lines), 64'(1 << tgt));
            chk(lvl ? "R4 status set" : "R5 no status", 64'(status), lvl ? 64'(1 << ch) : 0);
            nxt();
            chk(lvl ? "R4 level held" : "R5 one-cycle pulse", 64'(irq_lines), lvl ? 64'(1 << tgt) : 0);
            clr = '1;
            nxt();
            clr = '0;
            chk("R8 clear", 64'({status, irq_lines}), 0);
          end
    legacy_en = 0; ch_level = '1;
    for (int k = 0; k < N_CH; k++) ch_route[k*RW +: RW] = RW'(k + 1);

    // R3 gating
    ch_en = 4'b1110; fire = 4'b0001; nxt(); fire = '0;
    chk("R3 ch_en off", 64'({status, irq_lines}), 0);
    ch_en = '1; glb_en = 0; fire = 4'b0010; nxt(); fire = '0;
    chk("R3 glb_en off", 64'({status, irq_lines, msg_valid}), 0);
    glb_en = 1; nxt();

    // R8 fire wins over clear; disable clears
    fire = 4'b0001; clr = 4'b0001; nxt(); fire = '0; clr = '0;
    chk("R8 fire beats clr", 64'(status), 1);
    ch_en = 4'b1110; nxt(); ch_en = '1;
    chk("R8 disable clears", 64'({status, irq_lines}), 0);
    fire = 4'b0010; nxt(); fire = '0;
    chk("R4 pre msg-on", 64'(irq_lines), 64'(1 << 2));
    ch_msg_en = 4'b0010; nxt();
    chk("R8 msg-on clears", 64'({status, irq_lines}), 0);
    ch_msg_en = '0; nxt();

    // R9 OR merge
    ch_route[2*RW +: RW] = 4'd5; ch_route[3*RW +: RW] = 4'd5;
    fire = 4'b1100; nxt(); fire = '0;
    chk("R9 shared line", 64'(irq_lines), 64'(1 << 5));
    clr = 4'b0100; nxt(); clr = '0;
    chk("R9 one cleared still high", 64'(irq_lines), 64'(1 << 5));
    clr = 4'b1000; nxt(); clr = '0;
    chk("R9 both cleared", 64'(irq_lines), 0);

    // R6 R7 messages
    ch_msg_en = '1; ch_level = '0; nxt();
    fire = 4'b0001; nxt(); fire = '0;
    chk("R6 msg valid", 64'(msg_valid), 1);
    chk("R6 msg addr", 64'(msg_addr), 64'(addr_of(0)));
    chk("R6 msg data", 64'(msg_data), 64'(data_of(0)));
    chk("R6 no line or status", 64'({status, irq_lines}), 0);
    nxt(); nxt();
    chk("R7 held", 64'({msg_valid, msg_addr, msg_data}), {31'b0, 1'b1, addr_of(0), data_of(0)});
    msg_ready = 1; nxt();
    chk("R7 accepted", 64'(msg_valid), 0);
    fire = 4'b1010; nxt(); fire = '0;
    chk("R7 lowest first", 64'({msg_valid, msg_addr, msg_data}), {31'b0, 1'b1, addr_of(1), data_of(1)});
    nxt();
    chk("R7 second", 64'({msg_valid, msg_addr, msg_data}), {31'b0, 1'b1, addr_of(3), data_of(3)});
    nxt();
    chk("R7 drained", 64'(msg_valid), 0);
    ch_msg_en = '0; msg_ready = 0;

    // R10 RTC pass-through
    rtc_irq_in = 1; nxt();
    chk("R10 rtc forwarded", 64'(irq_lines), 64'(1 << 8));
    legacy_en = 1; nxt();
    chk("R10 legacy blocks rtc", 64'(irq_lines), 0);
    legacy_en = 0; nxt();
    chk("R10 rtc restored", 64'(irq_lines), 64'(1 << 8));
    rtc_irq_in = 0; nxt();
    chk("R10 rtc low", 64'(irq_lines), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule